// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block observes the already-filtered SCL and SDA levels of an SMBus port, together with an indication that this node is holding SCL low, and raises one sticky timeout flag when a bus timing limit is exceeded. Everything runs on the kernel clock.

Two checkers feed the flag. Each has its own enable. The interval checker measures one continuous interval. In idle mode the interval is the time both lines stay high, and it uses a tick every 4 clocks. In low mode the interval is the time SCL stays low, and it uses a tick every 2048 clocks. The stretch checker adds up the clock-stretch time this node spends within one transfer window, in blocks of 2048 clocks. A pulse at the start of each transfer restarts this sum. Each checker has a 12-bit limit register. While its checker is enabled, a limit register (and the mode bit) cannot be written.

Top module: `smbus_tmo_mon`

## Requirements
- R1: After a synchronous active-high reset, `tmo_flag` is 0, both limit registers are 0 and the interval checker is in low mode (`a_cfg_idle` = 0).
- R2: In idle mode (mode bit 1) with the interval checker enabled, the flag reads 1 after the (L+1)×4-th consecutive clock edge at which SCL and SDA are both high, where L is the interval limit. It still reads 0 after the edge before that.
- R3: In low mode (mode bit 0) with the interval checker enabled, the flag reads 1 after the (L+1)×2048-th consecutive clock edge at which SCL is low. It still reads 0 after the edge before that.
- R4: Only continuous time counts for the interval checker. One edge at which the measured condition is false restarts the whole count.
- R5: With the stretch checker enabled, stretch time is counted in whole 2048-clock blocks of uninterrupted stretching. A partial block is discarded when stretching stops. Completed blocks are kept across pauses, and the flag reads 1 after the edge that completes block number L+1, where L is the stretch limit.
- R6: A one-cycle `xfer_start` pulse discards all stretch time accumulated so far.
- R7: A disabled checker never sets the flag, and enabling it starts its count from zero.
- R8: A write of the interval limit or mode bit while the interval checker is enabled is ignored.
- R9: A write of the stretch limit while the stretch checker is enabled is ignored.
- R10: The flag stays 1 until a one-cycle `flag_clr` is applied. Clearing takes effect at the next edge, but a checker firing at that same edge keeps the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |
| stretch_in | input | 1 | This node is holding SCL low |
| xfer_start | input | 1 | One-cycle pulse at the start of a transfer window |
| a_en | input | 1 | Interval checker enable |
| a_cfg_wr | input | 1 | Write strobe for interval limit and mode |
| a_cfg_limit | input | 12 | Interval limit value to write |
| a_cfg_idle | input | 1 | Mode to write: 1 idle (both lines high), 0 SCL low |
| b_en | input | 1 | Stretch checker enable |
| b_cfg_wr | input | 1 | Write strobe for stretch limit |
| b_cfg_limit | input | 12 | Stretch limit value to write |
| flag_clr | input | 1 | One-cycle clear of the timeout flag |
| tmo_flag | output | 1 | Sticky timeout flag |

## Verification
The flag is registered once after the tick that empties a checker's counter. It is therefore due right after clock edge number (L+1)×P, counted from the first edge that sees the condition, where P is 4 or 2048. The bench changes inputs on falling edges and counts rising edges exactly. It samples the flag on the falling edge after edge (L+1)×P−1, where it must read 0, and again after edge (L+1)×P, where it must read 1. Clears, ignored writes and start pulses are applied one cycle ahead of the window they affect, and their effect is judged by this same exact timing.

// File: rtl/smbus_tmo_pkg.sv
package smbus_tmo_pkg;
   localparam int unsigned LIMIT_W  = 12;
   localparam int unsigned IDLE_DIV = 4;
   localparam int unsigned LONG_DIV = 2048;

   typedef enum logic {
      MODE_SCL_LOW = 1'b0,
      MODE_IDLE    = 1'b1
   } a_mode_e;
endpackage

// File: rtl/tmo_prescale.sv
module tmo_prescale #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);
   localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

   initial begin
      if (DIV < 1 || (DIV & (DIV - 1)) != 0)
         $error("tmo_prescale: DIV must be a power of two");
   end

   generate
      if (DIV == 1) begin : g_bypass
         assign tick = run;
      end else begin : g_count
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk) begin
            if (rst || !run) pre_q <= '0;
            else             pre_q <= pre_q + 1'b1;
         end

         assign tick = run && (pre_q == PW'(DIV - 1));

         // R4
         prescale_restart_chk: assert property (@(posedge clk) disable iff (rst)
            !run |=> (pre_q == '0));
      end
   endgenerate
endmodule

// File: rtl/tmo_interval.sv
module tmo_interval
   import smbus_tmo_pkg::*;
#(
   parameter int unsigned LW       = LIMIT_W,
   parameter int unsigned FAST_DIV = IDLE_DIV,
   parameter int unsigned SLOW_DIV = LONG_DIV
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  a_mode_e       mode,
   input  logic          scl,
   input  logic          sda,
   input  logic [LW-1:0] limit,
   output logic          hit
);
   logic          cond, run_fast, run_slow, tick_fast, tick_slow, tick;
   logic [LW-1:0] cnt_q;

   initial begin
      if (FAST_DIV >= SLOW_DIV)
         $error("tmo_interval: FAST_DIV must be below SLOW_DIV");
   end

   always_comb begin
      cond = en && ((mode == MODE_IDLE) ? (scl && sda) : !scl);
   end
   assign run_fast = cond && (mode == MODE_IDLE);
   assign run_slow = cond && (mode == MODE_SCL_LOW);

   tmo_prescale #(.DIV(FAST_DIV)) u_pre_fast (
      .clk(clk), .rst(rst), .run(run_fast), .tick(tick_fast));
   tmo_prescale #(.DIV(SLOW_DIV)) u_pre_slow (
      .clk(clk), .rst(rst), .run(run_slow), .tick(tick_slow));

   assign tick = tick_fast || tick_slow;
   assign hit  = tick && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst)                 cnt_q <= '0;
      else if (!cond)          cnt_q <= limit;
      else if (hit)            cnt_q <= limit;
      else if (tick)           cnt_q <= cnt_q - 1'b1;
   end

   // R4
   interval_reload_chk: assert property (@(posedge clk) disable iff (rst)
      !cond |=> (cnt_q == $past(limit)));

   // R7
   interval_off_chk: assert property (@(posedge clk) disable iff (rst)
      !en |-> !hit);
endmodule

// File: rtl/tmo_stretch.sv
module tmo_stretch
   import smbus_tmo_pkg::*;
#(
   parameter int unsigned LW  = LIMIT_W,
   parameter int unsigned DIV = LONG_DIV
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic          stretch,
   input  logic          start,
   input  logic [LW-1:0] limit,
   output logic          hit
);
   logic          run, tick;
   logic [LW-1:0] acc_q;

   assign run = en && stretch && !start;

   tmo_prescale #(.DIV(DIV)) u_pre (
      .clk(clk), .rst(rst), .run(run), .tick(tick));

   assign hit = tick && (acc_q == '0);

   always_ff @(posedge clk) begin
      if (rst)                acc_q <= '0;
      else if (!en || start)  acc_q <= limit;
      else if (hit)           acc_q <= limit;
      else if (tick)          acc_q <= acc_q - 1'b1;
   end

   // R5
   stretch_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (en && !stretch && !start) |=> $stable(acc_q));

   // R6
   stretch_restart_chk: assert property (@(posedge clk) disable iff (rst)
      start |=> (acc_q == $past(limit)));

   // R7
   stretch_off_chk: assert property (@(posedge clk) disable iff (rst)
      !en |-> !hit);
endmodule

// File: rtl/smbus_tmo_mon.sv
module smbus_tmo_mon
   import smbus_tmo_pkg::*;
#(
   parameter int unsigned LW       = LIMIT_W,
   parameter int unsigned FAST_DIV = IDLE_DIV,
   parameter int unsigned SLOW_DIV = LONG_DIV
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          scl_in,
   input  logic          sda_in,
   input  logic          stretch_in,
   input  logic          xfer_start,
   input  logic          a_en,
   input  logic          a_cfg_wr,
   input  logic [LW-1:0] a_cfg_limit,
   input  logic          a_cfg_idle,
   input  logic          b_en,
   input  logic          b_cfg_wr,
   input  logic [LW-1:0] b_cfg_limit,
   input  logic          flag_clr,
   output logic          tmo_flag
);
   logic [LW-1:0] lim_a_q, lim_b_q;
   a_mode_e       mode_q;
   logic          hit_a, hit_b;

   initial begin
      if (LW < 1 || LW > 16) $error("smbus_tmo_mon: LW out of range");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lim_a_q <= '0;
         mode_q  <= MODE_SCL_LOW;
      end else if (a_cfg_wr && !a_en) begin
         lim_a_q <= a_cfg_limit;
         mode_q  <= a_mode_e'(a_cfg_idle);
      end
   end

   always_ff @(posedge clk) begin
      if (rst)                     lim_b_q <= '0;
      else if (b_cfg_wr && !b_en)  lim_b_q <= b_cfg_limit;
   end

   tmo_interval #(.LW(LW), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_chk_a (
      .clk(clk), .rst(rst), .en(a_en), .mode(mode_q),
      .scl(scl_in), .sda(sda_in), .limit(lim_a_q), .hit(hit_a));

   tmo_stretch #(.LW(LW), .DIV(SLOW_DIV)) u_chk_b (
      .clk(clk), .rst(rst), .en(b_en), .stretch(stretch_in),
      .start(xfer_start), .limit(lim_b_q), .hit(hit_b));

   always_ff @(posedge clk) begin
      if (rst)                 tmo_flag <= 1'b0;
      else if (hit_a || hit_b) tmo_flag <= 1'b1;
      else if (flag_clr)       tmo_flag <= 1'b0;
   end

   // R8
   cfg_a_lock_chk: assert property (@(posedge clk) disable iff (rst)
      a_en |=> ($stable(lim_a_q) && $stable(mode_q)));

   // R9
   cfg_b_lock_chk: assert property (@(posedge clk) disable iff (rst)
      b_en |=> $stable(lim_b_q));

   // R10
   flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (tmo_flag && !flag_clr) |=> tmo_flag);

   // R10
   flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (flag_clr && !hit_a && !hit_b) |=> !tmo_flag);
endmodule

// File: tb/smbus_tmo_mon_tb.sv
module smbus_tmo_mon_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        scl_in = 1'b1, sda_in = 1'b1, stretch_in = 1'b0, xfer_start = 1'b0;
   logic        a_en = 1'b0, a_cfg_wr = 1'b0, a_cfg_idle = 1'b0;
   logic        b_en = 1'b0, b_cfg_wr = 1'b0, flag_clr = 1'b0;
   logic [11:0] a_cfg_limit = '0, b_cfg_limit = '0;
   logic        tmo_flag;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   smbus_tmo_mon u_dut (
      .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
      .stretch_in(stretch_in), .xfer_start(xfer_start),
      .a_en(a_en), .a_cfg_wr(a_cfg_wr), .a_cfg_limit(a_cfg_limit),
      .a_cfg_idle(a_cfg_idle), .b_en(b_en), .b_cfg_wr(b_cfg_wr),
      .b_cfg_limit(b_cfg_limit), .flag_clr(flag_clr), .tmo_flag(tmo_flag));

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic exp);
      checks++;
      if (tmo_flag !== exp) begin
         errors++;
         $display("FAIL %s: tmo_flag=%b expected %b at %0t", req, tmo_flag, exp, $time);
      end
   endtask

   task automatic clear_flag();
      flag_clr = 1'b1; step(1); flag_clr = 1'b0;
   endtask

   task automatic write_a(input logic [11:0] lim, input logic idle);
      a_cfg_limit = lim; a_cfg_idle = idle; a_cfg_wr = 1'b1; step(1); a_cfg_wr = 1'b0;
   endtask

   task automatic write_b(input logic [11:0] lim);
      b_cfg_limit = lim; b_cfg_wr = 1'b1; step(1); b_cfg_wr = 1'b0;
   endtask

   // R1: reset state; limit 0 in low mode, so SCL low fires after 2048 edges
   task automatic t_reset();
      chk("R1 reset flag", 1'b0);
      a_en = 1'b1; scl_in = 1'b0;
      step(2047); chk("R1 default low mode, one edge early", 1'b0);
      step(1);    chk("R1 default low mode fires at 2048", 1'b1);
      scl_in = 1'b1; a_en = 1'b0; clear_flag();
      chk("R10 clear", 1'b0);
   endtask

   // R2, R4, R10: idle mode, limit 2 -> 12 edges
   task automatic t_idle();
      write_a(12'd2, 1'b1);
      sda_in = 1'b0; a_en = 1'b1; step(2);
      sda_in = 1'b1; step(11); chk("R2 idle one edge early", 1'b0);
      step(1);                 chk("R2 idle fires at 12", 1'b1);
      sda_in = 1'b0; step(3);  chk("R10 sticky", 1'b1);
      clear_flag();            chk("R10 cleared", 1'b0);
      sda_in = 1'b1; step(8); sda_in = 1'b0; step(1); sda_in = 1'b1;
      step(11); chk("R4 restart after SDA low", 1'b0);
      step(1);  chk("R4 fires 12 edges after restart", 1'b1);
      sda_in = 1'b0; clear_flag();
      sda_in = 1'b1; step(6); scl_in = 1'b0; step(1); scl_in = 1'b1;
      step(11);          chk("R4 restart after SCL low", 1'b0);
      flag_clr = 1'b1; step(1); flag_clr = 1'b0;
      chk("R10 firing wins over clear", 1'b1);
      sda_in = 1'b0; clear_flag();
   endtask

   // R8: writes while enabled are ignored (limit 0 / low mode would fire earlier)
   task automatic t_lock_a();
      write_a(12'd0, 1'b0);
      sda_in = 1'b1; step(11); chk("R8 locked write ignored, early", 1'b0);
      step(1);                 chk("R8 old limit and mode kept", 1'b1);
      sda_in = 1'b0; a_en = 1'b0; clear_flag();
   endtask

   // R3, R7: low mode limit 1 -> 4096 edges, and disabled checker stays quiet
   task automatic t_low();
      write_a(12'd1, 1'b0);
      sda_in = 1'b1; scl_in = 1'b0; step(5000);
      chk("R7 disabled interval checker", 1'b0);
      scl_in = 1'b1; a_en = 1'b1; step(1);
      scl_in = 1'b0; step(4095); chk("R3 low one edge early", 1'b0);
      step(1);                   chk("R3 low fires at 4096", 1'b1);
      scl_in = 1'b1; a_en = 1'b0; clear_flag();
   endtask

   // R5, R9: cumulative stretch, limit 1 -> two full blocks
   task automatic t_stretch();
      write_b(12'd1);
      stretch_in = 1'b1; step(3000);
      chk("R7 disabled stretch checker", 1'b0);
      stretch_in = 1'b0; b_en = 1'b1; step(1);
      write_b(12'd0);
      xfer_start = 1'b1; step(1); xfer_start = 1'b0;
      stretch_in = 1'b1; step(2048); chk("R9 locked write ignored", 1'b0);
      stretch_in = 1'b0; step(5);
      stretch_in = 1'b1; step(1000); stretch_in = 1'b0; step(3);
      stretch_in = 1'b1; step(2047); chk("R5 partial block dropped", 1'b0);
      step(1);                       chk("R5 second block fires", 1'b1);
      stretch_in = 1'b0; clear_flag();
   endtask

   // R6: start pulse discards accumulated blocks
   task automatic t_start();
      xfer_start = 1'b1; step(1); xfer_start = 1'b0;
      stretch_in = 1'b1; step(2048); stretch_in = 1'b0;
      xfer_start = 1'b1; step(1); xfer_start = 1'b0;
      stretch_in = 1'b1; step(2048); chk("R6 start restarts sum", 1'b0);
      step(2048);                    chk("R6 fires after two new blocks", 1'b1);
      stretch_in = 1'b0; b_en = 1'b0; clear_flag();
   endtask

   initial begin
      step(3);
      rst = 1'b0;
      t_reset();
      t_idle();
      t_lock_a();
      t_low();
      t_stretch();
      t_start();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: run did not finish, actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule